// File: doc/BRIEF.md
# Serial Receiver with Triggered Byte Queue

This block is the receive half of a byte-oriented asynchronous serial port. A shift receiver watches the serial line on a sixteen-times-baud sampling tick. It confirms a start bit at the middle of its bit period and then takes each data bit, least significant first, at the centre of its bit cell. Each finished byte is pushed into a sixteen-entry first-in first-out queue. The processor drains the queue with a single-cycle read strobe, and the head byte is always present on the read-data port.

The interrupt fires on fill level, not on the arrival of any byte. A two-bit select chooses one of four thresholds. The interrupt stays high while the enable is set and the number of queued bytes is at or above the chosen threshold. A byte that finishes while all sixteen entries are occupied is dropped, and the stored bytes are left as they were. That loss raises a sticky overrun flag, which clears when the processor strobes a line-status read.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the queue is empty (`fifo_count` = 0), `irq` is low and `overrun` is low.
- R2: A frame is one low start bit, eight data bits with bit 0 first on the line, and one stop bit, each lasting 16 sampling ticks. After the frame, the byte is queued with its bits in the order they were received, and `rd_data` shows the oldest queued byte.
- R3: A low pulse on the idle line that has gone high again by the 8th sampling tick after detection is discarded, and no byte is queued.
- R4: The queue holds up to 16 bytes whatever threshold is selected, and returns them in arrival order. The count changes by at most one per cycle.
- R5: With 16 bytes stored, a further received byte is not stored: the count stays 16 and the queue contents and their order are unchanged.
- R6: `overrun` is set by a byte that completes while the queue holds 16 bytes, and it stays set until cleared.
- R7: A one-cycle `lsr_rd` strobe clears `overrun`, unless an overrun occurs in the same cycle.
- R8: `trig_sel` encodes the threshold as 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes. `irq` is high when `irq_en` is 1 and `fifo_count` is at or above the threshold.
- R9: `irq` falls as soon as the count drops below the threshold, and `irq` is low whenever `irq_en` is 0.
- R10: A read strobe while the queue is empty has no effect: the count stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Sampling enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Pop strobe for the head byte |
| rd_data | output | 8 | Oldest queued byte |
| lsr_rd | input | 1 | Line-status read strobe that clears the overrun flag |
| overrun | output | 1 | Sticky overrun flag |
| irq_en | input | 1 | Interrupt enable |
| trig_sel | input | 2 | Threshold select |
| irq | output | 1 | Data-available interrupt |
| fifo_count | output | 5 | Number of queued bytes |

## Verification
The assertions check on every cycle that the count moves by at most one step and that a full queue stays frozen when it is not read. They also check that the overrun flag only rises after a cycle with a full queue, that a status read with no new overrun leaves the flag clear, that the interrupt is silent while disabled, and that an empty read leaves the count at zero. Only the bench's scenarios can show the serial side. That covers bit order across whole frames, rejection of a short start glitch, the arrival order of sixteen bytes, and the exact crossing point of each of the four thresholds.

// File: rtl/rx_trig_pkg.sv
package rx_trig_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_t;

   // fill threshold selected by the 2-bit select field
   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/rx_line_sampler.sv
module rx_line_sampler
   import rx_trig_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   output logic              valid_o,
   output logic [DATA_W-1:0] byte_o
);
   localparam int TW = $clog2(OSR);
   localparam int BW = $clog2(DATA_W) + 1;
   localparam logic [TW-1:0] MID  = TW'(OSR / 2 - 1);
   localparam logic [TW-1:0] LAST = TW'(OSR - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
      $error("OSR must be a power of two of at least 4");
   end

   logic line;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line = rxd;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= '1;
         end else begin
            sr[0] <= rxd;
            for (int k = 1; k < SYNC_STAGES; k++) sr[k] <= sr[k-1];
         end
      end
      assign line = sr[SYNC_STAGES-1];
   end

   rx_state_t         state;
   logic [TW-1:0]     tcnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         tcnt    <= '0;
         bidx    <= '0;
         shreg   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (tick) begin
            case (state)
               RX_IDLE: begin
                  if (!line) begin
                     state <= RX_START;
                     tcnt  <= '0;
                  end
               end
               RX_START: begin
                  if (tcnt == MID) begin
                     tcnt <= '0;
                     bidx <= '0;
                     state <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (tcnt == LAST) begin
                     tcnt  <= '0;
                     shreg <= {line, shreg[DATA_W-1:1]};
                     if (bidx == LAST_BIT) state <= RX_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               default: begin
                  if (tcnt == LAST) begin
                     tcnt    <= '0;
                     valid_o <= 1'b1;
                     state   <= RX_IDLE;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign byte_o = shreg;
endmodule

// File: rtl/rx_byte_store.sv
module rx_byte_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic              clr_ovr,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              ovr
);
   if (DEPTH != (1 << PTR_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [DATA_W-1:0] mem [DEPTH];
   logic full, empty, do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    mem[i] <= '0;
         else if (do_push && wr_ptr == PTR_W'(i))       mem[i] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
         if (push && full)  ovr <= 1'b1;
         else if (clr_ovr)  ovr <= 1'b0;
      end
   end

   assign head = mem[rd_ptr];
endmodule

// File: rtl/rx_trig_irq.sv
module rx_trig_irq
   import rx_trig_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             irq_en,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] count,
   output logic             irq
);
   logic [CNT_W-1:0] level;
   assign level = CNT_W'(trig_level(sel));
   assign irq   = irq_en && (count >= level);
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rxd,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              lsr_rd,
   output logic              overrun,
   input  logic              irq_en,
   input  logic [1:0]        trig_sel,
   output logic              irq,
   output logic [CNT_W-1:0]  fifo_count
);
   if (DEPTH < 14) begin : g_bad_thresh
      $error("DEPTH must reach the highest threshold of 14");
   end

   logic              rx_valid;
   logic [DATA_W-1:0] rx_byte;

   rx_line_sampler #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
      .valid_o(rx_valid), .byte_o(rx_byte)
   );

   rx_byte_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(rx_valid), .push_data(rx_byte),
      .pop(rd_en), .clr_ovr(lsr_rd), .head(rd_data), .count(fifo_count),
      .ovr(overrun)
   );

   rx_trig_irq #(.CNT_W(CNT_W)) u_irq (
      .irq_en(irq_en), .sel(trig_sel), .count(fifo_count), .irq(irq)
   );
endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rd_en,
   input logic              lsr_rd,
   input logic              irq_en,
   input logic              irq,
   input logic              overrun,
   input logic [CNT_W-1:0]  count,
   input logic [DATA_W-1:0] rd_data
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1
                || count + 1'b1 == $past(count)));

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL && !rd_en) |=> (count == FULL && $stable(rd_data)));

   p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(count) == FULL);

   p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && (count != FULL || !rx_valid)) |=> !overrun);

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && rd_en && !rx_valid) |=> count == '0);
endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_en(rd_en), .lsr_rd(lsr_rd),
   .irq_en(irq_en), .irq(irq), .overrun(overrun), .count(fifo_count), .rd_data(rd_data)
);

// File: tb/rx_trig_fifo_bench.sv
module rx_trig_fifo_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rxd = 1'b1, rd_en = 1'b0, lsr_rd = 1'b0, irq_en = 1'b0;
   logic [1:0] trig_sel = 2'b00;
   logic [7:0] rd_data;
   logic overrun, irq;
   logic [4:0] fifo_count;

   int checks = 0, fails = 0;
   logic [7:0] model[$];
   logic model_ovr = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_trig_fifo u_rx_trig_fifo (
      .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .rxd(rxd), .rd_en(rd_en),
      .rd_data(rd_data), .lsr_rd(lsr_rd), .overrun(overrun), .irq_en(irq_en),
      .trig_sel(trig_sel), .irq(irq), .fifo_count(fifo_count)
   );

   function automatic int lvl(input logic [1:0] s);
      case (s)
         2'b00: return 1;
         2'b01: return 4;
         2'b10: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic logic exp_irq();
      return irq_en && (model.size() >= lvl(trig_sel));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      check(fifo_count == 5'(model.size()), {req, " count"}, fifo_count, model.size());
      check(irq == exp_irq(), {req, " irq (R8)"}, irq, exp_irq());
   endtask

   task automatic send_bit(input logic b);
      rxd = b;
      repeat (16) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(b[i]);
      send_bit(1'b1);
      repeat (3) @(negedge clk);
      if (model.size() < DEPTH) model.push_back(b);
      else model_ovr = 1'b1;
   endtask

   task automatic pop_byte(input string req);
      if (model.size() > 0)
         check(rd_data == model[0], {req, " head"}, rd_data, model[0]);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (model.size() > 0) void'(model.pop_front());
   endtask

   task automatic read_status(input string req);
      check(overrun == model_ovr, {req, " overrun"}, overrun, model_ovr);
      lsr_rd = 1'b1;
      @(negedge clk);
      lsr_rd = 1'b0;
      model_ovr = 1'b0;
      check(overrun == 1'b0, "R7 cleared by status read", overrun, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(fifo_count == 0, "R1 count", fifo_count, 0);
      check(irq == 0, "R1 irq", irq, 0);
      check(overrun == 0, "R1 overrun", overrun, 0);

      // R10 read of empty queue
      pop_byte("R10");
      @(negedge clk);
      check(fifo_count == 0, "R10 empty read", fifo_count, 0);

      // R3 short glitch
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (40) @(negedge clk);
      check(fifo_count == 0, "R3 glitch rejected", fifo_count, 0);

      // R2 bit order, R8 thresholds while filling
      irq_en = 1'b1;
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         while (model.size() < lvl(2'(s)) - 1) send_byte(8'($urandom));
         @(negedge clk);
         check_state("R8 below threshold");
         send_byte(8'($urandom));
         check_state("R8 at threshold");
      end
      send_byte(8'h01);
      send_byte(8'h80);
      check(fifo_count == 16, "R4 holds 16", fifo_count, 16);
      check(overrun == 0, "R6 no overrun at 16", overrun, 0);

      // R5/R6 overflow
      send_byte(8'hA5);
      check(fifo_count == 16, "R5 count stays full", fifo_count, 16);
      check(overrun == 1, "R6 overrun set", overrun, 1);
      repeat (5) @(negedge clk);
      check(overrun == 1, "R6 overrun sticky", overrun, 1);
      read_status("R7");

      // R9 disable and falling edge
      irq_en = 1'b0;
      @(negedge clk);
      check(irq == 0, "R9 disabled", irq, 0);
      irq_en = 1'b1;
      trig_sel = 2'b11;
      while (model.size() > 14) pop_byte("R4");
      check_state("R9 at 14");
      pop_byte("R4");
      check(irq == 0, "R9 falls below 14", irq, 0);

      // R2/R4 drain in order
      while (model.size() > 0) pop_byte("R2 R4 order");
      check_state("R4 drained");

      // random mix
      for (int n = 0; n < 300; n++) begin
         int unsigned r = $urandom % 8;
         if (r < 4) begin
            if (model.size() < DEPTH || ($urandom % 4) == 0) send_byte(8'($urandom));
         end else if (r < 6) begin
            pop_byte("R2 R4 random");
         end else if (r == 6) begin
            read_status("R6");
         end else begin
            trig_sel = 2'($urandom);
            irq_en = 1'($urandom);
            @(negedge clk);
         end
         check_state("R8 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule